// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the ordered series of column addresses that a memory burst visits. A one-cycle start pulse carries a starting column, a length select (four or eight beats) and an ordering select (sequential wrap or interleaved). From the next cycle the block presents one column address per clock, together with a valid flag and a last flag. After the last beat it goes idle.

Only the low column bits that lie inside the burst window are reordered: bits [1:0] for a four-beat burst, bits [2:0] for an eight-beat burst. All higher column bits are copied unchanged to every beat. An eight-beat sequential burst does not count linearly modulo eight. It first wraps inside the four-beat group the start lies in, then runs the same low-bit pattern in the other group. A start request that arrives while a burst is running is dropped, and a one-cycle error pulse reports it.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is applied, and after it is released until the first start, `valid_o`, `last_o` and `err_o` are 0.
- R2: A start pulse seen at a clock edge while idle makes `valid_o` 1 from that edge on, for exactly 4 consecutive cycles when `long_i` is 0 and exactly 8 when `long_i` is 1.
- R3: `last_o` is 1 only on the final beat of a burst, and `valid_o` is 0 in the cycle after it unless a new burst has been accepted.
- R4: With `long_i`=0 and `ilv_i`=0 (sequential), column bits [1:0] on beat i equal (start[1:0] + i) mod 4.
- R5: With `long_i`=0 and `ilv_i`=1 (interleaved), column bits [1:0] on beat i equal start[1:0] XOR i.
- R6: With `long_i`=1 and `ilv_i`=1, column bits [2:0] on beat i equal start[2:0] XOR i.
- R7: With `long_i`=1 and `ilv_i`=0, column bits [1:0] on beat i equal (start[1:0] + i) mod 4. Bit 2 equals start[2] on beats 0 to 3 and its inverse on beats 4 to 7.
- R8: Column bits above bit 1 for four-beat bursts, and above bit 2 for eight-beat bursts, equal the starting column on every beat.
- R9: A start while a burst is running has no effect on the running burst's addresses, length or flags. It makes `err_o` 1 for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Burst request pulse |
| col_i | input | COL_W | Starting column address |
| long_i | input | 1 | 0 selects 4 beats, 1 selects 8 beats |
| ilv_i | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | The current beat is the final one |
| err_o | output | 1 | A start arrived during a busy burst (one cycle) |

## Verification
The assertions assume that `start_i`, `col_i`, `long_i` and `ilv_i` are settled at each rising edge. They also assume that the configuration inputs matter only in the cycle where `start_i` is high. The stimulus changes every input on the falling edge and holds it for a whole cycle. The sweep covers every low start offset under each length and ordering, with several upper-bit patterns. Collisions are made only by deliberate starts in the middle of a burst, and each one uses a different column so that a wrongly accepted request would show on the address outputs.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;
  localparam int unsigned BL_SHORT = 4;
  localparam int unsigned BL_LONG  = 8;
  localparam int unsigned IDX_W    = $clog2(BL_LONG);

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  typedef struct packed {
    logic   long_burst;
    order_e order;
  } burst_cfg_t;
endpackage

// File: rtl/bcs_rst_sync.sv
`timescale 1ns/1ps
module bcs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bcs_ctrl.sv
`timescale 1ns/1ps
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  burst_cfg_t       cfg_i,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o,
  output burst_cfg_t       cfg_o,
  output logic [COL_W-1:0] base_o,
  output logic             last_o,
  output logic             err_o
);
  localparam logic [IDX_W-1:0] IDX_END_S = IDX_W'(BL_SHORT - 1);
  localparam logic [IDX_W-1:0] IDX_END_L = IDX_W'(BL_LONG - 1);

  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] base_q;
  logic             err_q, err_d;
  logic             load;
  logic             final_beat;

  assign load       = start_i && !active_q;
  assign final_beat = active_q &&
                      (idx_q == (cfg_q.long_burst ? IDX_END_L : IDX_END_S));

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    err_d    = start_i && active_q;
    if (load) begin
      active_d = 1'b1;
      idx_d    = '0;
    end else if (active_q) begin
      if (final_beat) begin
        active_d = 1'b0;
        idx_d    = '0;
      end else begin
        idx_d = idx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      err_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{long_burst: 1'b0, order: ORD_SEQ};
      base_q <= '0;
    end else if (load) begin
      cfg_q  <= cfg_i;
      base_q <= col_i;
    end
  end

  assign active_o = active_q;
  assign idx_o    = idx_q;
  assign cfg_o    = cfg_q;
  assign base_o   = base_q;
  assign last_o   = final_beat;
  assign err_o    = err_q;

  AST_SHORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !cfg_q.long_burst |-> idx_q <= IDX_END_S); // R2
  AST_LAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    final_beat |=> !active_q || $past(start_i)); // R3
  AST_ERR_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && active_q |=> err_q); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(start_i) && $past(active_q)); // R9
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && $past(active_q) |-> $stable(base_q) && $stable(cfg_q)); // R9
endmodule

// File: rtl/bcs_addr_gen.sv
`timescale 1ns/1ps
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [IDX_W-1:0] idx_i,
  input  burst_cfg_t       cfg_i,
  output logic [COL_W-1:0] col_o
);
  localparam int unsigned SUB_W = $clog2(BL_SHORT);

  logic [SUB_W-1:0] sub_seq;
  logic [SUB_W-1:0] sub_ilv;
  logic [SUB_W-1:0] sub_sel;
  logic             group_bit;

  assign sub_seq   = base_i[SUB_W-1:0] + idx_i[SUB_W-1:0];
  assign sub_ilv   = base_i[SUB_W-1:0] ^ idx_i[SUB_W-1:0];
  assign sub_sel   = (cfg_i.order == ORD_ILV) ? sub_ilv : sub_seq;
  // both orderings flip the group bit on the second half of a long burst
  assign group_bit = cfg_i.long_burst ? (base_i[SUB_W] ^ idx_i[SUB_W])
                                      : base_i[SUB_W];

  generate
    if (COL_W > SUB_W + 1) begin : g_upper
      assign col_o = {base_i[COL_W-1:SUB_W+1], group_bit, sub_sel};
    end else begin : g_narrow
      assign col_o = {group_bit, sub_sel};
    end
  endgenerate
endmodule

// File: rtl/burst_col_seq.sv
`timescale 1ns/1ps
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             long_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  logic             rst_sync_n;
  logic             active;
  logic [IDX_W-1:0] idx;
  burst_cfg_t       cfg_in, cfg_run;
  logic [COL_W-1:0] base;

  assign cfg_in = '{long_burst: long_i, order: order_e'(ilv_i)};

  bcs_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bcs_ctrl #(.COL_W(COL_W)) i_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .start_i(start_i), .col_i(col_i),
    .cfg_i(cfg_in), .active_o(active), .idx_o(idx), .cfg_o(cfg_run),
    .base_o(base), .last_o(last_o), .err_o(err_o)
  );

  bcs_addr_gen #(.COL_W(COL_W)) i_addr_gen (
    .base_i(base), .idx_i(idx), .cfg_i(cfg_run), .col_o(col_o)
  );

  assign valid_o = active;

  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    last_o |-> valid_o); // R3
  AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_o && !last_o |=> valid_o); // R2
  AST_UPPER_STABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_o && $past(valid_o) && !$past(last_o) |-> $stable(col_o[COL_W-1:3])); // R8
endmodule

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;
  localparam int unsigned COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic             long_i = 1'b0;
  logic             ilv_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, err_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
    .long_i(long_i), .ilv_i(ilv_i), .col_o(col_o), .valid_o(valid_o),
    .last_o(last_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(input int s, input bit lng, input bit ilv, input int i);
    int lo, grp, hi;
    if (ilv) lo = (s % 4) ^ (i % 4);
    else     lo = ((s % 4) + i) % 4;
    if (lng) begin
      hi  = (s / 8) * 8;
      grp = ((s / 4) % 2 + i / 4) % 2;
      return hi + grp * 4 + lo;
    end
    hi = (s / 4) * 4;
    return hi + lo;
  endfunction

  function automatic string req_of(input bit lng, input bit ilv);
    if (!lng) return ilv ? "R5" : "R4";
    return ilv ? "R6" : "R7";
  endfunction

  // drive at negedge, check each beat at the following negedges
  task automatic run_burst(input int s, input bit lng, input bit ilv,
                           input int clash_beat, input int clash_col);
    int n;
    n = lng ? 8 : 4;
    @(negedge clk);
    start_i = 1'b1; col_i = COL_W'(s); long_i = lng; ilv_i = ilv;
    @(negedge clk);
    start_i = 1'b0; col_i = '0; long_i = ~lng; ilv_i = ~ilv;
    for (int b = 0; b < n; b++) begin
      check(valid_o === 1'b1, "R2 valid", int'(valid_o), 1);
      check(col_o === COL_W'(exp_col(s, lng, ilv, b)), req_of(lng, ilv),
            int'(col_o), exp_col(s, lng, ilv, b));
      check(col_o[COL_W-1:3] === COL_W'(s) >> 3, "R8 upper",
            int'(col_o[COL_W-1:3]), s / 8);
      check(last_o === (b == n - 1), "R3 last", int'(last_o), int'(b == n - 1));
      check(err_o === (clash_beat >= 0 && b == clash_beat + 1), "R9 err",
            int'(err_o), int'(clash_beat >= 0 && b == clash_beat + 1));
      if (b == clash_beat) begin
        start_i = 1'b1; col_i = COL_W'(clash_col); long_i = 1'b0; ilv_i = ~ilv;
      end
      @(negedge clk);
      start_i = 1'b0;
    end
    check(valid_o === 1'b0, "R3 idle", int'(valid_o), 0);
    check(last_o === 1'b0, "R3 idle last", int'(last_o), 0);
  endtask

  initial begin
    int uppers[3];
    uppers[0] = 0; uppers[1] = 'h2A8; uppers[2] = 'h3F8;
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0, "R1 valid", int'(valid_o), 0);
    check(last_o === 1'b0, "R1 last", int'(last_o), 0);
    check(err_o === 1'b0, "R1 err", int'(err_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(valid_o === 1'b0, "R1 post valid", int'(valid_o), 0);
    check(err_o === 1'b0, "R1 post err", int'(err_o), 0);

    foreach (uppers[u])
      for (int l = 0; l < 2; l++)
        for (int t = 0; t < 2; t++)
          for (int s = 0; s < 8; s++)
            run_burst(uppers[u] + s, l[0], t[0], -1, 0);

    // mid-burst starts: must be dropped and flagged
    run_burst('h155, 1'b1, 1'b0, 2, 'h0AA);
    run_burst('h2B3, 1'b1, 1'b1, 6, 'h111);
    run_burst('h0C6, 1'b0, 1'b0, 0, 'h3FF);
    run_burst('h37D, 1'b0, 1'b1, 2, 'h002);
    // back-to-back bursts after idle
    run_burst('h003, 1'b1, 1'b0, -1, 0);
    run_burst('h004, 1'b0, 1'b1, -1, 0);
    check(err_o === 1'b0, "R9 err clear", int'(err_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule